// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O peripheral with a 32-bit register interface. Software reads the synchronised pin levels and sets an output value and a per-pin output enable. The block drives `pin_out` only where the enable is set, and the pad logic outside the block uses `pin_oe` as the driver enable.

Each pin can raise two kinds of interrupt. A level interrupt fires while the pin sits at its chosen active level. An edge interrupt comes from a latched event flag, which is set by the chosen transition and cleared by software writing 1 to that bit. Each kind has its own polarity register and its own mask. All enabled pin interrupts are ORed into one summary. The summary appears in a separate chip-level status register, and that register has its own mask. The masked summary is the single interrupt line `chip_irq`.

The register bus is a simple single-cycle strobe:
- `bus_en` together with `bus_we` writes `bus_wdata` at the clock edge.
- Read data is a combinational decode of `bus_addr` while `bus_en` is high.
- Address bit 8 selects the chip-level register group.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_out` and `pin_oe` are zero, and `chip_irq` is low.
- R2: Reading offset 0x000 returns `pin_in` after a two-flop synchroniser. A change on a pin is not visible after one clock edge and is visible after the second.
- R3: Output value (0x004) and output enable (0x008) read back as written. `pin_oe` equals the enable, and `pin_out` equals value AND enable.
- R4: Pin i has a level interrupt when bit i of ((synchronised input XOR level polarity) AND level mask) is 1. Level polarity is at 0x010 and level mask at 0x014; a polarity bit of 0 means active high and 1 means active low.
- R5: Event flag i (0x018) is set by the edge selected by edge polarity bit i (0x024: 0 = rising, 1 = falling), whatever the edge mask holds. The opposite edge has no effect. The flag is readable on the third clock edge after the pin changes.
- R6: Writing 1 to an event flag bit clears that bit. Writing 0 leaves the bit unchanged.
- R7: If a new edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R8: Pin i has an edge interrupt when bit i of (event flags AND edge mask) is 1. The edge mask is at 0x01C.
- R9: Bit 0 of the chip status register (0x120) is the OR of all level and edge interrupts. All other bits read 0, and writes to the register have no effect.
- R10: Bit 0 of the chip mask register (0x124) is writable and its other bits read 0. `chip_irq` equals chip status bit 0 AND chip mask bit 0.
- R11: Unmapped offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 9 | Byte offset; bit 8 selects the chip-level group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output value, gated by the enable |
| pin_oe | output | NUM_PINS | Per-pin driver enable |
| chip_irq | output | 1 | Masked chip-level interrupt request |

## Verification
Assertions check four things on every cycle:
- a fresh edge always leaves its flag set, even when a clearing write lands in the same cycle;
- a flag cleared without a coinciding edge reads zero next cycle, and no flag falls without a clearing write;
- `chip_irq` never rises with the chip mask clear, and always rises when any enabled pin interrupt is active under the mask;
- `pin_out` is never high where `pin_oe` is low.

Only the directed scenarios can show the rest:
- the two- and three-edge latencies through the synchroniser and edge detector;
- the polarity decoding of both interrupt kinds;
- the exact cycle of a colliding clear;
- that writes to read-only or unmapped offsets leave every register unchanged.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t OFS_DIN       = 9'h000;
  localparam reg_addr_t OFS_DOUT      = 9'h004;
  localparam reg_addr_t OFS_OE        = 9'h008;
  localparam reg_addr_t OFS_LVL_POL   = 9'h010;
  localparam reg_addr_t OFS_LVL_MASK  = 9'h014;
  localparam reg_addr_t OFS_EVT_FLAG  = 9'h018;
  localparam reg_addr_t OFS_EVT_MASK  = 9'h01C;
  localparam reg_addr_t OFS_EVT_POL   = 9'h024;
  localparam reg_addr_t OFS_CHIP_STAT = 9'h120;
  localparam reg_addr_t OFS_CHIP_MASK = 9'h124;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIN,
    SEL_DOUT,
    SEL_OE,
    SEL_LVL_POL,
    SEL_LVL_MASK,
    SEL_EVT_FLAG,
    SEL_EVT_MASK,
    SEL_EVT_POL,
    SEL_CHIP_STAT,
    SEL_CHIP_MASK
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] edge_pol,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;
  logic [WIDTH-1:0] new_edge;

  always_comb begin
    // a changed bit whose new value differs from its polarity bit is the chosen edge
    new_edge = (level_in ^ prev_q) & (level_in ^ edge_pol);
    flag_d   = (flag_q & ~clr_mask) | new_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level_in;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

  // R7: a detected edge wins over a simultaneous clear
  a_r7_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_edge) |=> ((flag_q & $past(new_edge)) == $past(new_edge)));

  // R6: cleared bits without a coinciding edge read zero next cycle
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~new_edge)) |=> ((flag_q & $past(clr_mask & ~new_edge)) == '0));

  // R6: no flag falls unless a clear was written for it
  a_r6_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_q) & ~$past(clr_mask)) & ~flag_q) == '0));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] level_pol,
  input  logic [WIDTH-1:0] level_mask,
  input  logic [WIDTH-1:0] flags,
  input  logic [WIDTH-1:0] flag_mask,
  output logic [WIDTH-1:0] level_irq,
  output logic [WIDTH-1:0] edge_irq,
  output logic             pin_summary
);
  always_comb begin
    level_irq   = (level_in ^ level_pol) & level_mask;
    edge_irq    = flags & flag_mask;
    pin_summary = (|level_irq) | (|edge_irq);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                chip_irq
);
  localparam int PW = NUM_PINS;

  reg_sel_e      sel;
  logic          wr_stb;
  logic [PW-1:0] wr_pins;

  logic [PW-1:0] dout_q, oe_q, lpol_q, lmask_q, emask_q, epol_q;
  logic          cmask_q;

  logic [PW-1:0] din_sync;
  logic [PW-1:0] flags;
  logic [PW-1:0] flag_clr;
  logic [PW-1:0] level_irq;
  logic [PW-1:0] edge_irq;
  logic          pin_summary;

  // address decode
  always_comb begin
    unique case (bus_addr)
      OFS_DIN:       sel = SEL_DIN;
      OFS_DOUT:      sel = SEL_DOUT;
      OFS_OE:        sel = SEL_OE;
      OFS_LVL_POL:   sel = SEL_LVL_POL;
      OFS_LVL_MASK:  sel = SEL_LVL_MASK;
      OFS_EVT_FLAG:  sel = SEL_EVT_FLAG;
      OFS_EVT_MASK:  sel = SEL_EVT_MASK;
      OFS_EVT_POL:   sel = SEL_EVT_POL;
      OFS_CHIP_STAT: sel = SEL_CHIP_STAT;
      OFS_CHIP_MASK: sel = SEL_CHIP_MASK;
      default:       sel = SEL_NONE;
    endcase
    wr_stb   = bus_en & bus_we;
    wr_pins  = bus_wdata[PW-1:0];
    flag_clr = (wr_stb && sel == SEL_EVT_FLAG) ? wr_pins : '0;
  end

  // configuration registers with explicit write enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      lpol_q  <= '0;
      lmask_q <= '0;
      emask_q <= '0;
      epol_q  <= '0;
      cmask_q <= 1'b0;
    end else begin
      if (wr_stb && sel == SEL_DOUT)      dout_q  <= wr_pins;
      if (wr_stb && sel == SEL_OE)        oe_q    <= wr_pins;
      if (wr_stb && sel == SEL_LVL_POL)   lpol_q  <= wr_pins;
      if (wr_stb && sel == SEL_LVL_MASK)  lmask_q <= wr_pins;
      if (wr_stb && sel == SEL_EVT_MASK)  emask_q <= wr_pins;
      if (wr_stb && sel == SEL_EVT_POL)   epol_q  <= wr_pins;
      if (wr_stb && sel == SEL_CHIP_MASK) cmask_q <= bus_wdata[0];
    end
  end

  gpio_in_sync #(.WIDTH(PW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (din_sync)
  );

  gpio_edge_track #(.WIDTH(PW)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (din_sync),
    .edge_pol (epol_q),
    .clr_mask (flag_clr),
    .flags    (flags)
  );

  gpio_irq_merge #(.WIDTH(PW)) u_merge (
    .level_in    (din_sync),
    .level_pol   (lpol_q),
    .level_mask  (lmask_q),
    .flags       (flags),
    .flag_mask   (emask_q),
    .level_irq   (level_irq),
    .edge_irq    (edge_irq),
    .pin_summary (pin_summary)
  );

  // read mux, pin-wide values zero-extended to the bus width
  always_comb begin
    logic [PW-1:0] pin_val;
    pin_val   = '0;
    bus_rdata = '0;
    unique case (sel)
      SEL_DIN:       pin_val = din_sync;
      SEL_DOUT:      pin_val = dout_q;
      SEL_OE:        pin_val = oe_q;
      SEL_LVL_POL:   pin_val = lpol_q;
      SEL_LVL_MASK:  pin_val = lmask_q;
      SEL_EVT_FLAG:  pin_val = flags;
      SEL_EVT_MASK:  pin_val = emask_q;
      SEL_EVT_POL:   pin_val = epol_q;
      SEL_CHIP_STAT: bus_rdata[0] = pin_summary;
      SEL_CHIP_MASK: bus_rdata[0] = cmask_q;
      default:       pin_val = '0;
    endcase
    bus_rdata[PW-1:0] = bus_rdata[PW-1:0] | pin_val;
    if (!bus_en) bus_rdata = '0;
  end

  assign pin_oe   = oe_q;
  assign pin_out  = dout_q & oe_q;
  assign chip_irq = pin_summary & cmask_q;

  // R10: no request while the chip mask is clear
  a_r10_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !cmask_q |-> !chip_irq);

  // R9: any active enabled pin interrupt reaches the chip line under the mask
  a_r9_summary_reaches: assert property (@(posedge clk) disable iff (!rst_n)
    (cmask_q && ((|level_irq) || (|edge_irq))) |-> chip_irq);

  // R3: a pin is never driven high while its enable is low
  a_r3_oe_gates_out: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_we;
  logic [8:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          chip_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .chip_irq(chip_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [8:0] regs [10] = '{9'h000, 9'h004, 9'h008, 9'h010, 9'h014,
                              9'h018, 9'h01C, 9'h024, 9'h120, 9'h124};
    foreach (regs[k]) begin
      rd(regs[k], v);
      check($sformatf("R1 reg %h", regs[k]), v, 32'h0);
    end
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 chip_irq", {31'h0, chip_irq}, 32'h0);
  endtask

  task automatic t_data_in();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'hA5A5_0F0F;
    @(posedge clk);
    rd(9'h000, v);
    check("R2 one edge", v, 32'h0);
    rd(9'h000, v);
    check("R2 two edges", v, 32'hA5A5_0F0F);
    @(negedge clk);
    pin_in = '0;
    settle(4);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(9'h008, 32'h0000_FFFF);
    wr(9'h004, 32'h1234_5678);
    check("R3 pin_out", pin_out, 32'h0000_5678);
    check("R3 pin_oe", pin_oe, 32'h0000_FFFF);
    rd(9'h004, v);
    check("R3 dout readback", v, 32'h1234_5678);
    rd(9'h008, v);
    check("R3 oe readback", v, 32'h0000_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk);
    pin_in[0] = 1'b1;
    settle(3);
    wr(9'h014, 32'h1);
    rd(9'h120, v);
    check("R4 active high / R9 status", v, 32'h1);
    check("R10 masked off", {31'h0, chip_irq}, 32'h0);
    wr(9'h124, 32'h1);
    check("R10 mask on", {31'h0, chip_irq}, 32'h1);
    wr(9'h010, 32'h1);
    rd(9'h120, v);
    check("R4 active low, pin high", v, 32'h0);
    @(negedge clk);
    pin_in[0] = 1'b0;
    settle(2);
    rd(9'h120, v);
    check("R4 active low, pin low", v, 32'h1);
    wr(9'h014, 32'h0);
    wr(9'h010, 32'h0);
    rd(9'h120, v);
    check("R4 level mask off", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(9'h018, 32'hFFFF_FFFF);
    rd(9'h018, v);
    check("R6 clear all", v, 32'h0);
    @(negedge clk);
    pin_in[3] = 1'b1;
    repeat (2) @(posedge clk);
    rd(9'h018, v);
    check("R5 not yet after two edges", v, 32'h0);
    rd(9'h018, v);
    check("R5 rising latched unmasked", v, 32'h8);
    rd(9'h120, v);
    check("R8 edge mask clear", v, 32'h0);
    wr(9'h01C, 32'h8);
    rd(9'h120, v);
    check("R8 edge mask set", v, 32'h1);
    check("R10 edge request", {31'h0, chip_irq}, 32'h1);
    @(negedge clk);
    pin_in[3] = 1'b0;
    settle(4);
    rd(9'h018, v);
    check("R5 opposite edge ignored", v, 32'h8);
    wr(9'h018, 32'h0);
    rd(9'h018, v);
    check("R6 write zero keeps", v, 32'h8);
    wr(9'h018, 32'h8);
    rd(9'h018, v);
    check("R6 write one clears", v, 32'h0);
    check("R6 request drops", {31'h0, chip_irq}, 32'h0);
    wr(9'h024, 32'h10);
    @(negedge clk);
    pin_in[4] = 1'b1;
    settle(4);
    rd(9'h018, v);
    check("R5 falling pol ignores rise", v, 32'h0);
    @(negedge clk);
    pin_in[4] = 1'b0;
    settle(4);
    rd(9'h018, v);
    check("R5 falling edge latched", v, 32'h10);
    wr(9'h018, 32'h10);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk);
    pin_in[5] = 1'b1;
    settle(4);
    @(negedge clk);
    pin_in[5] = 1'b0;
    settle(4);
    rd(9'h018, v);
    check("R5 pin5 set before collision", v, 32'h20);
    @(negedge clk);
    pin_in[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 9'h018; bus_wdata = 32'h20;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
    rd(9'h018, v);
    check("R7 edge beats clear", v, 32'h20);
    wr(9'h018, 32'h20);
    rd(9'h018, v);
    check("R7 later clear works", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(9'h00C, 32'hFFFF_FFFF);
    wr(9'h020, 32'hFFFF_FFFF);
    wr(9'h104, 32'hFFFF_FFFF);
    rd(9'h00C, v);
    check("R11 read 0x00C", v, 32'h0);
    rd(9'h020, v);
    check("R11 read 0x020", v, 32'h0);
    rd(9'h104, v);
    check("R11 read 0x104", v, 32'h0);
    rd(9'h004, v);
    check("R11 dout untouched", v, 32'h1234_5678);
    rd(9'h014, v);
    check("R11 level mask untouched", v, 32'h0);
    wr(9'h120, 32'hFFFF_FFFF);
    rd(9'h120, v);
    check("R9 status write ignored", v, 32'h0);
    check("R9 no request", {31'h0, chip_irq}, 32'h0);
    wr(9'h124, 32'hFFFF_FFFE);
    rd(9'h124, v);
    check("R10 mask bit0 only", v, 32'h0);
    wr(9'h124, 32'hFFFF_FFFF);
    rd(9'h124, v);
    check("R10 mask readback", v, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_data_in();
    t_output();
    t_level();
    t_edge();
    t_collision();
    t_unmapped();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule